// File: doc/BRIEF.md
# Vector Coprocessor Control Register Block

This block is the host-visible control point for a vector coprocessor. A word-wide register bus (byte address, write strobe, read strobe, write data, read data) reaches a status word, a hardware semaphore, a program counter and the parameter registers that a separate transfer engine uses to move data between local memory and DRAM. The block stores those transfer parameters and pulses a start strobe toward the engine. It does not move data itself. It also drives the coprocessor interrupt request toward the system interrupt controller.

The status word is never written as a plain value. Each writable flag has a clear command bit and a set command bit. A flag changes only when exactly one bit of its pair is 1. The interrupt request uses the same rule through its own pair, but that pair has no stored status bit. The semaphore is taken by reading it, and any write to it frees it. The program counter accepts writes only while the coprocessor is halted.

Read data is combinational from the current address and state. All state changes take place at the rising clock edge that samples a strobe.

Top module: `cpctl_regs`

## Requirements
- R1: After reset, halt reads 1. The status word otherwise reads 0. The interrupt request is 0, the semaphore is free, the program counter is 0 and the step count is 0.
- R2: Status word write command bits (address 0x10) are: halt clear bit 0 and set bit 1; single-step clear bit 5 and set bit 6; interrupt-on-break clear bit 7 and set bit 8; signal i clear bit 9+2i and set bit 10+2i. A flag clears when only its clear bit is 1, sets when only its set bit is 1, and holds when both or neither are 1.
- R3: Broke is set by a pulse on `brk_i` and cleared by write bit 2. No write bit sets it. If a pulse and a clear arrive in the same cycle, the pulse wins.
- R4: Write bits 3 (clear) and 4 (set) lower and raise `irq_o` under the same exclusive rule as R2. No stored status bit changes.
- R5: `step_count_o` counts cycles with `step_i` high. A status write that sets halt (set-only) makes it 0 on the next cycle, overriding `step_i`. A write with both halt bits does not.
- R6: A read at 0x1C returns the semaphore (0 = obtained, 1 = taken) and leaves it at 1. Any write at 0x1C frees it to 0. A read and a write in the same cycle leave it free.
- R7: A write at 0x20 loads the program counter only while halt is 1. A read at 0x20 returns the counter with bits 1:0 cleared.
- R8: Reads at 0x00 and 0x04 return the engine's last completed local and DRAM addresses, with bits 2:0 cleared and limited to 13 and 24 bits. Writes there latch the same masking of write data onto the outputs toward the engine.
- R9: A write at 0x08 or 0x0C latches the length word and pulses `dma_start_o` for one cycle. `dma_to_dram_o` is 0 for 0x08 and 1 for 0x0C. A read at either address returns the latched length.
- R10: Status read bits are: 0 halt, 1 broke, 2 busy, 3 full, 4 I/O full, 5 single-step, 6 interrupt-on-break, and 7+i signal i. A read at 0x14 returns only the full bit. Reads at 0x18 and at unmapped addresses return 0. Writes to 0x14 and 0x18 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address within the block |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (needed to acquire the semaphore) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| brk_i | input | 1 | Coprocessor break event, sets broke |
| step_i | input | 1 | Coprocessor stepped one instruction |
| dma_busy_i | input | 1 | Transfer engine busy |
| dma_full_i | input | 1 | Transfer engine request queue full |
| io_full_i | input | 1 | Transfer engine I/O full |
| last_local_i | input | 13 | Last completed local-memory address |
| last_dram_i | input | 24 | Last completed DRAM address |
| halt_o | output | 1 | Halt flag |
| single_step_o | output | 1 | Single-step flag |
| intr_brk_o | output | 1 | Interrupt-on-break flag |
| signal_o | output | 8 | Software signal flags |
| irq_o | output | 1 | Interrupt request to the interrupt controller |
| step_count_o | output | 16 | Stepped-instruction count |
| pc_o | output | 12 | Program counter |
| dma_local_addr_o | output | 13 | Latched local-memory transfer address |
| dma_dram_addr_o | output | 24 | Latched DRAM transfer address |
| dma_len_o | output | 32 | Latched transfer length word |
| dma_start_o | output | 1 | One-cycle transfer start strobe |
| dma_to_dram_o | output | 1 | Direction of the started transfer |

## Verification
The assertions check on every cycle that halt and the interrupt request follow the exclusive-pair rule and hold otherwise. They also check that a break pulse always sets broke, that a set-halt write zeroes the step count, that the semaphore ends free after any write and taken after a lone read, that the program counter ignores writes while running, and that each length write gives exactly one start strobe with the right direction. Only the bench scenarios show the read values. These are the status bit layout, the masked address and counter views, the values returned by the semaphore, the reset values, and the pair rule applied to every single-step, interrupt-on-break and signal flag from both prior states.

// File: rtl/cpctl_pkg.sv
package cpctl_pkg;
  // word indices (byte address / 4)
  localparam int IDX_LOCAL   = 0;
  localparam int IDX_DRAM    = 1;
  localparam int IDX_LEN_IN  = 2;
  localparam int IDX_LEN_OUT = 3;
  localparam int IDX_STATUS  = 4;
  localparam int IDX_FULL    = 5;
  localparam int IDX_BUSY    = 6;
  localparam int IDX_SEM     = 7;
  localparam int IDX_PC      = 8;

  // status write command bits
  localparam int WB_CLR_HALT  = 0;
  localparam int WB_SET_HALT  = 1;
  localparam int WB_CLR_BROKE = 2;
  localparam int WB_CLR_IRQ   = 3;
  localparam int WB_SET_IRQ   = 4;
  localparam int WB_CLR_SSTEP = 5;
  localparam int WB_SET_SSTEP = 6;
  localparam int WB_CLR_IOB   = 7;
  localparam int WB_SET_IOB   = 8;
  localparam int WB_SIG_BASE  = 9;

  // status read bits
  localparam int RB_HALT     = 0;
  localparam int RB_BROKE    = 1;
  localparam int RB_BUSY     = 2;
  localparam int RB_FULL     = 3;
  localparam int RB_IOFULL   = 4;
  localparam int RB_SSTEP    = 5;
  localparam int RB_IOB      = 6;
  localparam int RB_SIG_BASE = 7;

  // exclusive clear/set: only one asserted bit of the pair acts
  function automatic logic pair_next(logic cur, logic clr, logic set);
    return (clr ^ set) ? set : cur;
  endfunction

  // address view: limited to w bits, 8-byte aligned
  function automatic logic [31:0] addr_view(logic [31:0] v, int unsigned w);
    logic [31:0] m;
    m = (32'h1 << w) - 32'h1;
    return v & m & ~32'h7;
  endfunction

  // counter view: limited to w bits, word aligned
  function automatic logic [31:0] pc_view(logic [31:0] v, int unsigned w);
    logic [31:0] m;
    m = (32'h1 << w) - 32'h1;
    return v & m & ~32'h3;
  endfunction
endpackage

// File: rtl/cpctl_pair_flag.sv
module cpctl_pair_flag
  import cpctl_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= pair_next(q, clr, set);
  end
endmodule

// File: rtl/cpctl_sem.sv
module cpctl_sem (
  input  logic clk,
  input  logic rst_n,
  input  logic acquire,
  input  logic release_w,
  output logic taken
);
  // a release in the same cycle as an acquire wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         taken <= 1'b0;
    else if (release_w) taken <= 1'b0;
    else if (acquire)   taken <= 1'b1;
  end
endmodule

// File: rtl/cpctl_rdmux.sv
module cpctl_rdmux
  import cpctl_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int LOCAL_AW = 13,
  parameter int DRAM_AW  = 24,
  parameter int PC_W     = 12
) (
  input  logic [IDX_W-1:0]    idx,
  input  logic [31:0]         status_w,
  input  logic [31:0]         len_w,
  input  logic [LOCAL_AW-1:0] local_a,
  input  logic [DRAM_AW-1:0]  dram_a,
  input  logic                dma_full,
  input  logic                sem,
  input  logic [PC_W-1:0]     pc,
  output logic [31:0]         rdata
);
  always_comb begin
    rdata = '0;
    case (idx)
      IDX_W'(IDX_LOCAL):   rdata = addr_view(32'(local_a), LOCAL_AW);
      IDX_W'(IDX_DRAM):    rdata = addr_view(32'(dram_a), DRAM_AW);
      IDX_W'(IDX_LEN_IN),
      IDX_W'(IDX_LEN_OUT): rdata = len_w;
      IDX_W'(IDX_STATUS):  rdata = status_w;
      IDX_W'(IDX_FULL):    rdata = 32'(dma_full);
      IDX_W'(IDX_SEM):     rdata = 32'(sem);
      IDX_W'(IDX_PC):      rdata = pc_view(32'(pc), PC_W);
      default:             rdata = '0;
    endcase
  end
endmodule

// File: rtl/cpctl_regs.sv
module cpctl_regs
  import cpctl_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int NUM_SIG  = 8,
  parameter int STEP_W   = 16,
  parameter int LOCAL_AW = 13,
  parameter int DRAM_AW  = 24,
  parameter int PC_W     = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic                bus_re,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                brk_i,
  input  logic                step_i,
  input  logic                dma_busy_i,
  input  logic                dma_full_i,
  input  logic                io_full_i,
  input  logic [LOCAL_AW-1:0] last_local_i,
  input  logic [DRAM_AW-1:0]  last_dram_i,
  output logic                halt_o,
  output logic                single_step_o,
  output logic                intr_brk_o,
  output logic [NUM_SIG-1:0]  signal_o,
  output logic                irq_o,
  output logic [STEP_W-1:0]   step_count_o,
  output logic [PC_W-1:0]     pc_o,
  output logic [LOCAL_AW-1:0] dma_local_addr_o,
  output logic [DRAM_AW-1:0]  dma_dram_addr_o,
  output logic [31:0]         dma_len_o,
  output logic                dma_start_o,
  output logic                dma_to_dram_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic             unused_lsb;
  assign widx       = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];

  // named decode events
  logic wr_local, wr_dram, wr_len_in, wr_len_out, wr_status, wr_sem, wr_pc, rd_sem;
  logic halt_set_evt;
  assign wr_local   = bus_we && (widx == IDX_W'(IDX_LOCAL));
  assign wr_dram    = bus_we && (widx == IDX_W'(IDX_DRAM));
  assign wr_len_in  = bus_we && (widx == IDX_W'(IDX_LEN_IN));
  assign wr_len_out = bus_we && (widx == IDX_W'(IDX_LEN_OUT));
  assign wr_status  = bus_we && (widx == IDX_W'(IDX_STATUS));
  assign wr_sem     = bus_we && (widx == IDX_W'(IDX_SEM));
  assign wr_pc      = bus_we && (widx == IDX_W'(IDX_PC));
  assign rd_sem     = bus_re && (widx == IDX_W'(IDX_SEM));
  assign halt_set_evt = wr_status && bus_wdata[WB_SET_HALT] && !bus_wdata[WB_CLR_HALT];

  // paired flags
  logic halt_q, sstep_q, iob_q, irq_q, broke_q, sem_q;
  logic [NUM_SIG-1:0] sig_q;

  cpctl_pair_flag #(.RST_VAL(1'b1)) u_halt (.clk(clk), .rst_n(rst_n),
    .clr(wr_status && bus_wdata[WB_CLR_HALT]), .set(wr_status && bus_wdata[WB_SET_HALT]), .q(halt_q));
  cpctl_pair_flag #(.RST_VAL(1'b0)) u_sstep (.clk(clk), .rst_n(rst_n),
    .clr(wr_status && bus_wdata[WB_CLR_SSTEP]), .set(wr_status && bus_wdata[WB_SET_SSTEP]), .q(sstep_q));
  cpctl_pair_flag #(.RST_VAL(1'b0)) u_iob (.clk(clk), .rst_n(rst_n),
    .clr(wr_status && bus_wdata[WB_CLR_IOB]), .set(wr_status && bus_wdata[WB_SET_IOB]), .q(iob_q));
  cpctl_pair_flag #(.RST_VAL(1'b0)) u_irq (.clk(clk), .rst_n(rst_n),
    .clr(wr_status && bus_wdata[WB_CLR_IRQ]), .set(wr_status && bus_wdata[WB_SET_IRQ]), .q(irq_q));

  for (genvar i = 0; i < NUM_SIG; i++) begin : g_sig
    cpctl_pair_flag #(.RST_VAL(1'b0)) u_sig (.clk(clk), .rst_n(rst_n),
      .clr(wr_status && bus_wdata[WB_SIG_BASE + 2*i]),
      .set(wr_status && bus_wdata[WB_SIG_BASE + 2*i + 1]),
      .q(sig_q[i]));
  end

  // broke: event sets, write clears, event wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   broke_q <= 1'b0;
    else if (brk_i)                               broke_q <= 1'b1;
    else if (wr_status && bus_wdata[WB_CLR_BROKE]) broke_q <= 1'b0;
  end

  // step counter
  logic [STEP_W-1:0] step_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            step_q <= '0;
    else if (halt_set_evt) step_q <= '0;
    else if (step_i)       step_q <= step_q + 1'b1;
  end

  cpctl_sem u_sem (.clk(clk), .rst_n(rst_n), .acquire(rd_sem), .release_w(wr_sem), .taken(sem_q));

  // program counter and transfer parameters
  logic [PC_W-1:0] pc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q             <= '0;
      dma_local_addr_o <= '0;
      dma_dram_addr_o  <= '0;
      dma_len_o        <= '0;
      dma_start_o      <= 1'b0;
      dma_to_dram_o    <= 1'b0;
    end else begin
      if (wr_pc && halt_q) pc_q <= bus_wdata[PC_W-1:0];
      if (wr_local) dma_local_addr_o <= LOCAL_AW'(addr_view(bus_wdata, LOCAL_AW));
      if (wr_dram)  dma_dram_addr_o  <= DRAM_AW'(addr_view(bus_wdata, DRAM_AW));
      if (wr_len_in || wr_len_out) begin
        dma_len_o     <= bus_wdata;
        dma_to_dram_o <= wr_len_out;
      end
      dma_start_o <= wr_len_in || wr_len_out;
    end
  end

  // status read word
  logic [31:0] status_w;
  always_comb begin
    status_w = '0;
    status_w[RB_HALT]   = halt_q;
    status_w[RB_BROKE]  = broke_q;
    status_w[RB_BUSY]   = dma_busy_i;
    status_w[RB_FULL]   = dma_full_i;
    status_w[RB_IOFULL] = io_full_i;
    status_w[RB_SSTEP]  = sstep_q;
    status_w[RB_IOB]    = iob_q;
    status_w[RB_SIG_BASE +: NUM_SIG] = sig_q;
  end

  cpctl_rdmux #(.IDX_W(IDX_W), .LOCAL_AW(LOCAL_AW), .DRAM_AW(DRAM_AW), .PC_W(PC_W)) u_rdmux (
    .idx(widx), .status_w(status_w), .len_w(dma_len_o), .local_a(last_local_i),
    .dram_a(last_dram_i), .dma_full(dma_full_i), .sem(sem_q), .pc(pc_q), .rdata(bus_rdata));

  assign halt_o        = halt_q;
  assign single_step_o = sstep_q;
  assign intr_brk_o    = iob_q;
  assign signal_o      = sig_q;
  assign irq_o         = irq_q;
  assign step_count_o  = step_q;
  assign pc_o          = pc_q;
endmodule

// File: rtl/cpctl_regs_chk.sv
module cpctl_regs_chk
  import cpctl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int STEP_W = 16,
  parameter int PC_W   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [31:0]       bus_wdata,
  input logic              brk_i,
  input logic              halt_o,
  input logic              irq_o,
  input logic [STEP_W-1:0] step_count_o,
  input logic [PC_W-1:0]   pc_o,
  input logic              dma_start_o,
  input logic              dma_to_dram_o,
  input logic              sem_q,
  input logic              broke_q
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] cidx;
  logic st_w, sem_w, sem_r, pc_w, len_w, len_out_w;
  assign cidx      = bus_addr[ADDR_W-1:2];
  assign st_w      = bus_we && (cidx == IDX_W'(IDX_STATUS));
  assign sem_w     = bus_we && (cidx == IDX_W'(IDX_SEM));
  assign sem_r     = bus_re && (cidx == IDX_W'(IDX_SEM));
  assign pc_w      = bus_we && (cidx == IDX_W'(IDX_PC));
  assign len_out_w = bus_we && (cidx == IDX_W'(IDX_LEN_OUT));
  assign len_w     = len_out_w || (bus_we && (cidx == IDX_W'(IDX_LEN_IN)));

  // R2
  halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w && bus_wdata[WB_SET_HALT] && !bus_wdata[WB_CLR_HALT]) |=> halt_o);
  // R2
  halt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w && bus_wdata[WB_CLR_HALT] && !bus_wdata[WB_SET_HALT]) |=> !halt_o);
  // R2
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_w && (bus_wdata[WB_CLR_HALT] ^ bus_wdata[WB_SET_HALT])) |=> $stable(halt_o));
  // R3
  broke_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_i |=> broke_q);
  // R3
  broke_norise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_i |=> !$rose(broke_q));
  // R4
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w && bus_wdata[WB_SET_IRQ] && !bus_wdata[WB_CLR_IRQ]) |=> irq_o);
  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_w && (bus_wdata[WB_CLR_IRQ] ^ bus_wdata[WB_SET_IRQ])) |=> $stable(irq_o));
  // R5
  step_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w && bus_wdata[WB_SET_HALT] && !bus_wdata[WB_CLR_HALT]) |=> (step_count_o == '0));
  // R6
  sem_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sem_w |=> !sem_q);
  // R6
  sem_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_r && !sem_w) |=> sem_q);
  // R7
  pc_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_w && !halt_o) |=> $stable(pc_o));
  // R7
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_w && halt_o) |=> (pc_o == $past(bus_wdata[PC_W-1:0])));
  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_w |=> (dma_start_o && (dma_to_dram_o == $past(len_out_w))));
  // R9
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !len_w |=> !dma_start_o);
endmodule

bind cpctl_regs cpctl_regs_chk #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
  .bus_wdata(bus_wdata), .brk_i(brk_i), .halt_o(halt_o), .irq_o(irq_o),
  .step_count_o(step_count_o), .pc_o(pc_o), .dma_start_o(dma_start_o),
  .dma_to_dram_o(dma_to_dram_o), .sem_q(sem_q), .broke_q(broke_q));

// File: tb/test_cpctl_regs.sv
module test_cpctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        brk = 1'b0, step = 1'b0, busy = 1'b0, full = 1'b0, iofull = 1'b0;
  logic [12:0] last_local = '0;
  logic [23:0] last_dram = '0;
  logic        halt, sstep, iob, irq, dstart, ddir;
  logic [7:0]  sig;
  logic [15:0] stepc;
  logic [11:0] pc;
  logic [12:0] dloc;
  logic [23:0] ddram;
  logic [31:0] dlen;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] mst = 32'h1;  // status model
  logic [31:0] d;

  always #5 clk = ~clk;

  cpctl_regs i_cpctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_re(re), .bus_wdata(wdata),
    .bus_rdata(rdata), .brk_i(brk), .step_i(step), .dma_busy_i(busy), .dma_full_i(full),
    .io_full_i(iofull), .last_local_i(last_local), .last_dram_i(last_dram), .halt_o(halt),
    .single_step_o(sstep), .intr_brk_o(iob), .signal_o(sig), .irq_o(irq), .step_count_o(stepc),
    .pc_o(pc), .dma_local_addr_o(dloc), .dma_dram_addr_o(ddram), .dma_len_o(dlen),
    .dma_start_o(dstart), .dma_to_dram_o(ddir));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] v);
    @(negedge clk); addr = a; wdata = v; we = 1'b1;
    @(negedge clk); we = 1'b0; #1;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; re = 1'b1; #1; v = rdata;
    @(negedge clk); re = 1'b0; #1;
  endtask

  function automatic int clr_pos(int p);
    if (p == 0) return 0;
    if (p == 1) return 5;
    if (p == 2) return 7;
    return 9 + 2 * (p - 3);
  endfunction

  function automatic int rd_pos(int p);
    if (p == 0) return 0;
    if (p == 1) return 5;
    if (p == 2) return 6;
    return 7 + (p - 3);
  endfunction

  task automatic finish_tb();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_tb();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;

    // R1 reset state
    rd(6'h10, d); chk("R1 status", d, 32'h1);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pc", 32'(pc), 0);
    chk("R1 step", 32'(stepc), 0);
    rd(6'h1C, d); chk("R1 sem", d, 0);
    wr(6'h1C, 0);

    // R2 sweep: every flag, both prior states, all four command pairs
    for (int p = 0; p < 11; p++)
      for (int pr = 0; pr < 2; pr++)
        for (int c = 0; c < 4; c++) begin
          wr(6'h10, 32'h1 << (clr_pos(p) + pr));
          mst[rd_pos(p)] = pr[0];
          wr(6'h10, 32'(c) << clr_pos(p));
          if (c == 1) mst[rd_pos(p)] = 1'b0;
          else if (c == 2) mst[rd_pos(p)] = 1'b1;
          rd(6'h10, d); chk("R2 pair", d, mst);
        end
    chk("R2 signal port", 32'(sig), 32'(mst[14:7]));

    // R4 interrupt pair
    for (int pr = 0; pr < 2; pr++)
      for (int c = 0; c < 4; c++) begin
        logic e;
        wr(6'h10, 32'h1 << (3 + pr));
        e = pr[0];
        wr(6'h10, 32'(c) << 3);
        if (c == 1) e = 1'b0; else if (c == 2) e = 1'b1;
        chk("R4 irq", 32'(irq), 32'(e));
        rd(6'h10, d); chk("R4 status unchanged", d, mst);
      end

    // R3 broke
    @(negedge clk); brk = 1'b1; @(negedge clk); brk = 1'b0; #1;
    rd(6'h10, d); chk("R3 set by event", 32'(d[1]), 1);
    wr(6'h10, 32'h01FF_FFFB);  // every command except clear-broke
    rd(6'h10, d); chk("R3 no write sets/clears", 32'(d[1]), 1);
    wr(6'h10, 32'h4);
    rd(6'h10, d); chk("R3 cleared", 32'(d[1]), 0);
    @(negedge clk); brk = 1'b1; addr = 6'h10; wdata = 32'h4; we = 1'b1;
    @(negedge clk); brk = 1'b0; we = 1'b0; #1;
    rd(6'h10, d); chk("R3 event wins", 32'(d[1]), 1);
    wr(6'h10, 32'h4);

    // R5 step counter
    @(negedge clk); step = 1'b1;
    repeat (5) @(negedge clk);
    step = 1'b0; #1;
    chk("R5 count", 32'(stepc), 5);
    wr(6'h10, 32'h3);
    chk("R5 both bits keep count", 32'(stepc), 5);
    wr(6'h10, 32'h2);
    chk("R5 halt set zeroes", 32'(stepc), 0);

    // R6 semaphore
    rd(6'h1C, d); chk("R6 first read obtains", d, 0);
    rd(6'h1C, d); chk("R6 second read taken", d, 1);
    wr(6'h1C, 32'h0);
    rd(6'h1C, d); chk("R6 release", d, 0);
    @(negedge clk); addr = 6'h1C; re = 1'b1; we = 1'b1;
    @(negedge clk); re = 1'b0; we = 1'b0; #1;
    rd(6'h1C, d); chk("R6 write wins", d, 0);
    wr(6'h1C, 32'h0);

    // R7 program counter
    for (int k = 0; k < 12; k++) begin
      int v, u;
      v = (k * 677 + 3) % 4096;
      u = (v + 1111) % 4096;
      wr(6'h10, 32'h2);
      wr(6'h20, 32'(v));
      rd(6'h20, d); chk("R7 halted load", d, 32'(v - v % 4));
      wr(6'h10, 32'h1);
      wr(6'h20, 32'(u));
      rd(6'h20, d); chk("R7 running ignored", d, 32'(v - v % 4));
      chk("R7 pc port", 32'(pc), 32'(v));
    end

    // R8 addresses
    for (int k = 0; k < 8; k++) begin
      int a, b;
      a = (k * 1237 + 5) % 8192;
      b = (k * 2796203 + 7) % 16777216;
      @(negedge clk); last_local = 13'(a); last_dram = 24'(b); #1;
      rd(6'h00, d); chk("R8 local view", d, 32'(a - a % 8));
      rd(6'h04, d); chk("R8 dram view", d, 32'(b - b % 8));
    end
    wr(6'h00, 32'hFFFF_FFFF); chk("R8 local latch", 32'(dloc), 32'h1FF8);
    wr(6'h04, 32'hFFFF_FFFF); chk("R8 dram latch", 32'(ddram), 32'hFF_FFF8);

    // R9 length / start
    @(negedge clk); addr = 6'h08; wdata = 32'h00AB_CDEF; we = 1'b1;
    @(negedge clk); we = 1'b0; #1;
    chk("R9 start in", 32'(dstart), 1);
    chk("R9 dir in", 32'(ddir), 0);
    @(negedge clk); #1; chk("R9 one cycle", 32'(dstart), 0);
    rd(6'h0C, d); chk("R9 length read", d, 32'h00AB_CDEF);
    @(negedge clk); addr = 6'h0C; wdata = 32'h1234_5678; we = 1'b1;
    @(negedge clk); we = 1'b0; #1;
    chk("R9 start out", 32'(dstart), 1);
    chk("R9 dir out", 32'(ddir), 1);
    rd(6'h08, d); chk("R9 length read alt", d, 32'h1234_5678);

    // R10 status inputs and auxiliary reads
    @(negedge clk); busy = 1'b1; full = 1'b1; iofull = 1'b1; #1;
    rd(6'h10, d); chk("R10 engine bits", d & 32'h1C, 32'h1C);
    rd(6'h14, d); chk("R10 full word", d, 1);
    rd(6'h18, d); chk("R10 busy word", d, 0);
    @(negedge clk); full = 1'b0; #1;
    rd(6'h14, d); chk("R10 full word low", d, 0);
    for (int a = 9; a < 16; a++) begin
      rd(6'(a * 4), d); chk("R10 unmapped", d, 0);
    end
    rd(6'h10, mst);
    wr(6'h14, 32'hFFFF_FFFF);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h10, d); chk("R10 write ignored", d, mst);

    finish_tb();
  end
endmodule